// File: doc/BRIEF.md
# Presettable BCD Display Timer

This block is a three-digit decimal up-counter that drives three seven-segment digit outputs directly. It holds its count as three binary-coded decimal digits, so no binary-to-decimal conversion sits between the count and the display. The count advances by one on each internal tick, and a prescaler makes that tick. A rate select picks between a short test interval and a long real-time interval. With a 50 MHz clock and the default parameters, the long interval is one second.

An active-low load strobe holds the counter at a 10-bit binary preset value. The preset is clamped to 999 and converted to three decimal digits. While the strobe is low, the prescaler is held cleared. After the strobe is released, the count resumes from the loaded value, and the first increment comes one full tick interval later. After 999 the count wraps to 000 and keeps going.

Top module: `bcd_display_timer`

## Requirements
- R1: While `rst_ni` is low, the count is 000 and each digit output shows the zero pattern. The reset is asynchronous.
- R2: On each tick the count rises by exactly one. A ones digit of 9 becomes 0 and carries into the tens digit, and a tens digit of 9 carries the same way into the hundreds digit. Between ticks the count does not change.
- R3: When a tick arrives at 999, the count becomes 000 and counting continues.
- R4: With `rate_sel_i` at 0, a tick occurs every FAST_DIV clocks (default 5). After reset is released, the count is 1 after FAST_DIV rising edges and still 0 after FAST_DIV-1 edges.
- R5: While `load_ni` is low, the count at each rising edge takes the decimal value of `preset_bin_i`. This value is visible from the first edge after the strobe goes low. A preset that changes while the strobe is held is followed.
- R6: A preset above 999 (for example 1000 or 1023) loads as 999.
- R7: Each digit output is 7 bits, active low, with bit 6 = segment g down to bit 0 = segment a. The patterns are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000.
- R8: With `rate_sel_i` at 1, a tick occurs every SLOW_DIV clocks (default 50,000,000).
- R9: Reset and a low `load_ni` both clear the prescaler. The first increment after the strobe is released comes on the interval-th rising edge after the last edge on which the strobe was sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Preset load strobe, active low, level sensitive |
| rate_sel_i | input | 1 | Tick interval select: 0 = FAST_DIV clocks, 1 = SLOW_DIV clocks |
| preset_bin_i | input | 10 | Binary preset value, clamped to 999 |
| seg_hund_o | output | 7 | Hundreds digit segments, active low, g..a |
| seg_tens_o | output | 7 | Tens digit segments, active low, g..a |
| seg_ones_o | output | 7 | Ones digit segments, active low, g..a |

## Verification
The assertions check on every cycle that each digit stays in the range 0 to 9 and that the count holds between ticks. They also check that a tick steps the ones digit by one, that a tick at 999 returns the count to 000, and that a low strobe loads the converted preset. They further check that ticks never come back-to-back and never arrive in the cycle right after a load, and that no digit output is ever blank. The exact tick interval in each mode, the clamping of out-of-range presets, and the full walk through all thousand values with correct segment patterns can only be shown by the bench scenarios. The bench counts clocks and decodes the displayed digits to check these.

// File: rtl/bcdt_pkg.sv
package bcdt_pkg;
    localparam int NDIG      = 3;
    localparam int PRESET_W  = 10;
    localparam int BCD_W     = 4 * NDIG;
    localparam int MAX_VALUE = (10 ** NDIG) - 1;

    typedef logic [3:0]            bcd_digit_t;
    typedef bcd_digit_t [NDIG-1:0] bcd_word_t;

    localparam bcd_word_t ALL_NINES = {NDIG{4'd9}};

    // active-low segments, bit 6 = g ... bit 0 = a
    function automatic logic [6:0] seg_of(input bcd_digit_t d);
        logic [6:0] s;
        case (d)
            4'd0:    s = 7'b1000000;
            4'd1:    s = 7'b1111001;
            4'd2:    s = 7'b0100100;
            4'd3:    s = 7'b0110000;
            4'd4:    s = 7'b0011001;
            4'd5:    s = 7'b0010010;
            4'd6:    s = 7'b0000010;
            4'd7:    s = 7'b1111000;
            4'd8:    s = 7'b0000000;
            4'd9:    s = 7'b0010000;
            default: s = 7'b1111111;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/bcdt_tick_gen.sv
module bcdt_tick_gen #(
    parameter int FAST_DIV = 5,
    parameter int SLOW_DIV = 50_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_ni,
    input  logic rate_sel_i,
    output logic tick_o
);
    localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic [CW-1:0] limit;
    logic          at_limit;

    always_comb begin
        st_d     = st_q;
        limit    = rate_sel_i ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
        // ">=" keeps a leftover count from a longer interval from running past
        at_limit = (st_q.cnt >= limit);
        if (!clr_ni || at_limit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        tick_o = clr_ni && at_limit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    generate
        if (FAST_DIV > 1 && SLOW_DIV > 1) begin : g_spacing
            assert_tick_spacing_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
            assert_clear_on_load_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
                !clr_ni |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/bcdt_bin2bcd.sv
module bcdt_bin2bcd
    import bcdt_pkg::*;
(
    input  logic [PRESET_W-1:0] bin_i,
    output bcd_word_t           bcd_o
);
    logic [PRESET_W-1:0] clamped;
    logic [BCD_W-1:0]    acc;

    always_comb begin
        clamped = (bin_i > PRESET_W'(MAX_VALUE)) ? PRESET_W'(MAX_VALUE) : bin_i;
        acc     = '0;
        // shift-and-add-3 conversion, one pass per input bit
        for (int b = PRESET_W - 1; b >= 0; b--) begin
            for (int d = 0; d < NDIG; d++) begin
                if (acc[4*d +: 4] >= 4'd5) acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
            end
            acc = {acc[BCD_W-2:0], clamped[b]};
        end
        for (int d = 0; d < NDIG; d++) bcd_o[d] = acc[4*d +: 4];
    end
endmodule

// File: rtl/bcdt_digit_chain.sv
module bcdt_digit_chain
    import bcdt_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      load_ni,
    input  logic      tick_i,
    input  bcd_word_t preset_i,
    output bcd_word_t digits_o
);
    typedef struct packed {
        bcd_word_t digits;
    } chain_state_t;

    chain_state_t st_d, st_q;
    logic         carry;

    always_comb begin
        st_d  = st_q;
        carry = 1'b0;
        if (!load_ni) begin
            st_d.digits = preset_i;
        end else if (tick_i) begin
            carry = 1'b1;
            for (int i = 0; i < NDIG; i++) begin
                if (carry) begin
                    if (st_q.digits[i] == 4'd9) begin
                        st_d.digits[i] = 4'd0;
                    end else begin
                        st_d.digits[i] = st_q.digits[i] + 4'd1;
                        carry          = 1'b0;
                    end
                end
            end
        end
        digits_o = st_q.digits;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < NDIG; g++) begin : g_range
            assert_digit_range_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
                st_q.digits[g] <= 4'd9);
        end
    endgenerate
endmodule

// File: rtl/bcdt_seg_enc.sv
module bcdt_seg_enc
    import bcdt_pkg::*;
(
    input  bcd_digit_t digit_i,
    output logic [6:0] seg_o
);
    always_comb seg_o = seg_of(digit_i);
endmodule

// File: rtl/bcd_display_timer.sv
module bcd_display_timer
    import bcdt_pkg::*;
#(
    parameter int FAST_DIV = 5,
    parameter int SLOW_DIV = 50_000_000
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_ni,
    input  logic                rate_sel_i,
    input  logic [PRESET_W-1:0] preset_bin_i,
    output logic [6:0]          seg_hund_o,
    output logic [6:0]          seg_tens_o,
    output logic [6:0]          seg_ones_o
);
    logic       tick_w;
    bcd_word_t  preset_bcd_w;
    bcd_word_t  digits_w;
    logic [6:0] seg_w [NDIG];

    bcdt_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_ni     (load_ni),
        .rate_sel_i (rate_sel_i),
        .tick_o     (tick_w)
    );

    bcdt_bin2bcd u_conv (
        .bin_i (preset_bin_i),
        .bcd_o (preset_bcd_w)
    );

    bcdt_digit_chain u_chain (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_ni  (load_ni),
        .tick_i   (tick_w),
        .preset_i (preset_bcd_w),
        .digits_o (digits_w)
    );

    generate
        for (genvar g = 0; g < NDIG; g++) begin : g_seg
            bcdt_seg_enc u_enc (
                .digit_i (digits_w[g]),
                .seg_o   (seg_w[g])
            );
            assert_seg_lit_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
                seg_w[g] != 7'b1111111);
        end
    endgenerate

    assign seg_ones_o = seg_w[0];
    assign seg_tens_o = seg_w[1];
    assign seg_hund_o = seg_w[2];

    assert_hold_between_ticks_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_ni && !tick_w) |=> $stable(digits_w));

    assert_ones_step_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_ni && tick_w && digits_w[0] != 4'd9) |=> digits_w[0] == $past(digits_w[0]) + 4'd1);

    assert_wrap_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_ni && tick_w && digits_w == ALL_NINES) |=> digits_w == '0);

    assert_load_value_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_ni |=> digits_w == $past(preset_bcd_w));
endmodule

// File: tb/sim_bcd_display_timer.sv
module sim_bcd_display_timer;
    localparam int FAST = 5;
    localparam int SLOW = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       rate_sel = 1'b0;
    logic [9:0] preset = '0;
    logic [6:0] seg_h, seg_t, seg_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bcd_display_timer #(.FAST_DIV(FAST), .SLOW_DIV(SLOW)) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .load_ni      (load_n),
        .rate_sel_i   (rate_sel),
        .preset_bin_i (preset),
        .seg_hund_o   (seg_h),
        .seg_tens_o   (seg_t),
        .seg_ones_o   (seg_o)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'b1000000;  1: return 7'b1111001;
            2: return 7'b0100100;  3: return 7'b0110000;
            4: return 7'b0011001;  5: return 7'b0010010;
            6: return 7'b0000010;  7: return 7'b1111000;
            8: return 7'b0000000;  9: return 7'b0010000;
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic int dec(input logic [6:0] s);
        for (int d = 0; d < 10; d++) if (s === pat(d)) return d;
        return -1000;
    endfunction

    function automatic int shown();
        int h, t, o;
        h = dec(seg_h); t = dec(seg_t); o = dec(seg_o);
        if (h < 0 || t < 0 || o < 0) return -1;
        return h * 100 + t * 10 + o;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input logic [9:0] v);
        load_n = 1'b0;
        preset = v;
        cyc(1);
    endtask

    task automatic t_reset_r1_r4();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 count during reset", shown(), 0);
        chk("R7 zero pattern hundreds", int'(seg_h), int'(7'b1000000));
        chk("R7 zero pattern ones", int'(seg_o), int'(7'b1000000));
        cyc(1);
        rst_n = 1'b1;
        cyc(FAST - 1);
        chk("R4 no tick before interval", shown(), 0);
        cyc(1);
        chk("R4 first tick after interval", shown(), 1);
    endtask

    task automatic t_sweep_r2_r3();
        int start;
        start = shown();
        for (int k = 1; k <= 1000; k++) begin
            cyc(FAST);
            chk("R2 sweep step", shown(), (start + k) % 1000);
        end
    endtask

    task automatic t_preset_r5_r9();
        do_load(10'b0111110011);
        chk("R5 preset 499 shown", shown(), 499);
        cyc(3);
        chk("R5 held while strobe low", shown(), 499);
        preset = 10'd123;
        cyc(1);
        chk("R5 follows changed preset", shown(), 123);
        preset = 10'd499;
        cyc(1);
        load_n = 1'b1;
        cyc(FAST - 1);
        chk("R9 no early tick after load", shown(), 499);
        cyc(1);
        chk("R9 first tick after release", shown(), 500);
    endtask

    task automatic t_clamp_r6_r3();
        do_load(10'd1023);
        chk("R6 clamp 1023", shown(), 999);
        do_load(10'd1000);
        chk("R6 clamp 1000", shown(), 999);
        load_n = 1'b1;
        cyc(FAST);
        chk("R3 wrap 999 to 000", shown(), 0);
        cyc(FAST);
        chk("R3 continues after wrap", shown(), 1);
    endtask

    task automatic t_carry_r2();
        do_load(10'd89);
        load_n = 1'b1;
        cyc(FAST);
        chk("R2 ones carry 89->90", shown(), 90);
        do_load(10'd199);
        load_n = 1'b1;
        cyc(FAST);
        chk("R2 tens carry 199->200", shown(), 200);
        chk("R7 digit 2 pattern", int'(seg_h), int'(7'b0100100));
    endtask

    task automatic t_slow_r8();
        do_load(10'd7);
        rate_sel = 1'b1;
        cyc(1);
        load_n = 1'b1;
        cyc(SLOW - 1);
        chk("R8 no tick before slow interval", shown(), 7);
        cyc(1);
        chk("R8 tick at slow interval", shown(), 8);
        cyc(SLOW);
        chk("R8 second slow tick", shown(), 9);
        chk("R7 digit 9 pattern", int'(seg_o), int'(7'b0010000));
        do_load(10'd9);
        rate_sel = 1'b0;
        cyc(1);
        load_n = 1'b1;
        cyc(FAST);
        chk("R4 back to fast rate", shown(), 10);
    endtask

    task automatic t_reset_midrun_r1();
        cyc(2);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset mid-count", shown(), 0);
        cyc(1);
        rst_n = 1'b1;
        cyc(FAST);
        chk("R1 count restarts from zero", shown(), 1);
    endtask

    initial begin
        cyc(2);
        t_reset_r1_r4();
        t_sweep_r2_r3();
        t_preset_r5_r9();
        t_clamp_r6_r3();
        t_carry_r2();
        t_slow_r8();
        t_reset_midrun_r1();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule